// File: doc/BRIEF.md
# Multiplexed Row/Column Programming Port

This block is the parallel programming-mode front end of a byte-wide memory with an 18-bit address space. The host presents the address in two halves over one shared 11-bit address bus: a single active-low row/column strobe captures the 11 low-order bits when it falls and the 7 high-order bits when it rises. Data moves over an 8-bit bus, split here into an input, an output and an output-enable so that the pad cells sit outside the block. An active-low write enable and an active-low output enable frame each transfer.

The host strobes are asynchronous to the system clock. The block brings each one into the clock domain through a two-flop synchroniser and detects edges from the synchronised samples. It then joins the two address halves and turns host transfers into single-cycle read and write requests on an internal memory port. A ready/busy output mirrors the busy bit of a status register supplied by the command side. While that bit shows busy, host writes are dropped and host reads return the status byte instead of array data.

The address and data pins must stay stable from the strobe edge until the synchronised edge has been seen, which takes three system clocks.

Top module: `mrc_port`

## Requirements
- R1: On each falling edge of `rc_n`, address bits 10..0 are taken from `addr_in[10:0]` and used as bits 10..0 of every later request address.
- R2: On each rising edge of `rc_n`, address bits 17..11 are taken from `addr_in[6:0]`, so a request address is {column bits, row bits} with the column in `mem_addr[17:11]`.
- R3: On each rising edge of `we_n` while `status_in[7]` is 1 (ready), exactly one single-cycle `mem_wr_req` pulse is issued, carrying the assembled address on `mem_addr` and the `dq_in` byte on `mem_wdata`.
- R4: A rising edge of `we_n` while `status_in[7]` is 0 (busy) is ignored: no `mem_wr_req` pulse is issued.
- R5: On each falling edge of `oe_n` while ready, exactly one single-cycle `mem_rd_req` pulse is issued with the assembled address. The byte that the memory returns on `mem_rdata` in the following cycle is then driven on `dq_out` with `dq_oe` high until `oe_n` rises.
- R6: On a falling edge of `oe_n` while busy, no `mem_rd_req` is issued, and `dq_out` carries the `status_in` byte sampled at that edge, with `dq_oe` high.
- R7: `dq_oe` is 0 in every cycle in which `oe_n` is 1, and falls in the same cycle that `oe_n` rises.
- R8: `ry_by` equals `status_in[7]` for every status value.
- R9: After reset, `mem_wr_req`, `mem_rd_req` and `dq_oe` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | 11 | Shared row/column address pins |
| rc_n | input | 1 | Row/column strobe: falling edge takes the row, rising edge takes the column |
| oe_n | input | 1 | Active-low output enable from the host |
| we_n | input | 1 | Active-low write enable; the write is taken on its rising edge |
| dq_in | input | 8 | Data bus value coming from the pads |
| dq_out | output | 8 | Data bus value going to the pads |
| dq_oe | output | 1 | Pad output enable for the data bus |
| ry_by | output | 1 | Ready (1) / busy (0), taken from status bit 7 |
| status_in | input | 8 | Status register from the command side; bit 7 = 1 means ready |
| mem_rd_req | output | 1 | Single-cycle read request to the memory port |
| mem_wr_req | output | 1 | Single-cycle write request to the memory port |
| mem_addr | output | 18 | Request address, held until the next request |
| mem_wdata | output | 8 | Write data for the request |
| mem_rdata | input | 8 | Read data, valid in the cycle after `mem_rd_req` |

## Verification
A row or column register holding the wrong value does not show at the ports until the next request. It then appears as a wrong `mem_addr` three clocks after the enable edge, so every sweep step pairs an address load with a transfer. A synchroniser or edge detector that misfires shows as a missing or doubled request pulse within four clocks of the host edge. A drive flag left set shows as `dq_oe` high in the cycle after `oe_n` returns high, or as a stale byte on the next read. A busy decision taken from the wrong bit shows as a request that should have been dropped, or as array data where the status byte was expected.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    // Edge events seen on the synchronised host strobes
    typedef struct packed {
        logic rc_fall;
        logic rc_rise;
        logic we_rise;
        logic oe_fall;
        logic oe_rise;
    } strobe_ev_t;

    // Synchronised strobe levels, all active low
    typedef struct packed {
        logic rc;
        logic we;
        logic oe;
    } strobe_lvl_t;

endpackage

// File: rtl/mrc_sync.sv
module mrc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    // Each bit gets its own chain; reset to 1 (strobes idle high)
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/mrc_edge.sv
module mrc_edge
    import mrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  strobe_lvl_t lvl,
    output strobe_ev_t  ev
);
    typedef struct packed {
        strobe_lvl_t prev;
    } edge_st_t;

    edge_st_t st_d;
    edge_st_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;

        ev         = '0;
        ev.rc_fall = st_q.prev.rc & ~lvl.rc;
        ev.rc_rise = ~st_q.prev.rc & lvl.rc;
        ev.we_rise = ~st_q.prev.we & lvl.we;
        ev.oe_fall = st_q.prev.oe & ~lvl.oe;
        ev.oe_rise = ~st_q.prev.oe & lvl.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: '{rc: 1'b1, we: 1'b1, oe: 1'b1}};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mrc_addr_asm.sv
module mrc_addr_asm
    import mrc_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 7,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_ev_t        ev,
    input  logic [ROW_W-1:0]  addr_in,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } asm_st_t;

    asm_st_t st_d;
    asm_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (ev.rc_fall) begin
            st_d.row = addr_in;
        end
        if (ev.rc_rise) begin
            st_d.col = addr_in[COL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = {st_q.col, st_q.row};
endmodule

// File: rtl/mrc_port.sv
module mrc_port
    import mrc_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 7,
    parameter int DATA_W      = 8,
    parameter int BUSY_BIT    = 7,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  addr_in,
    input  logic              rc_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              ry_by,
    input  logic [DATA_W-1:0] status_in,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        logic              wr_req;
        logic              rd_req;
        logic              rd_wait;
        logic              drive;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } port_st_t;

    strobe_lvl_t       lvl;
    strobe_ev_t        ev;
    logic [ADDR_W-1:0] asm_addr;
    logic              ready;
    port_st_t          st_d;
    port_st_t          st_q;

    mrc_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rc_n, we_n, oe_n}),
        .sync_out ({lvl.rc, lvl.we, lvl.oe})
    );

    mrc_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .ev    (ev)
    );

    mrc_addr_asm #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .addr_in (addr_in),
        .addr    (asm_addr)
    );

    assign ready = status_in[BUSY_BIT];

    always_comb begin
        st_d         = st_q;
        st_d.wr_req  = 1'b0;
        st_d.rd_req  = 1'b0;
        st_d.rd_wait = st_q.rd_req;

        // Host released the bus: stop driving
        if (ev.oe_rise) begin
            st_d.drive = 1'b0;
        end

        if (ev.we_rise) begin
            if (ready) begin
                st_d.wr_req = 1'b1;
                st_d.addr   = asm_addr;
                st_d.wdata  = dq_in;
            end
        end else if (ev.oe_fall) begin
            st_d.drive = 1'b0;
            if (ready) begin
                st_d.rd_req = 1'b1;
                st_d.addr   = asm_addr;
            end else begin
                st_d.rdata = status_in;
                st_d.drive = 1'b1;
            end
        end

        // Array byte arrives one cycle after the request
        if (st_q.rd_wait && !lvl.oe) begin
            st_d.rdata = mem_rdata;
            st_d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_wr_req = st_q.wr_req;
    assign mem_rd_req = st_q.rd_req;
    assign mem_addr   = st_q.addr;
    assign mem_wdata  = st_q.wdata;
    assign dq_out     = st_q.rdata;
    // The raw pin gates the pads so release needs no clock
    assign dq_oe      = st_q.drive & ~oe_n;
    assign ry_by      = ready;
endmodule

// File: rtl/mrc_port_chk.sv
module mrc_port_chk #(
    parameter int DATA_W   = 8,
    parameter int BUSY_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] status_in,
    input logic              mem_rd_req,
    input logic              mem_wr_req
);
    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |=> !mem_wr_req);

    p_wr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> $past(status_in[BUSY_BIT]));

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !dq_oe);

    p_rd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> $past(status_in[BUSY_BIT]));

    p_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_req_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
endmodule

bind mrc_port mrc_port_chk #(
    .DATA_W   (DATA_W),
    .BUSY_BIT (BUSY_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe),
    .status_in  (status_in),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req)
);

// File: tb/mrc_port_bench.sv
module mrc_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr_in = '0;
    logic        rc_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic        ry_by;
    logic [7:0]  status_in = 8'h80;
    logic        mem_rd_req;
    logic        mem_wr_req;
    logic [17:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [17:0] wr_addr_seen = '0;
    logic [7:0]  wr_data_seen = '0;
    logic [17:0] rd_addr_seen = '0;
    bit done = 0;

    always #2 clk = ~clk;

    mrc_port u_mrc_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .rc_n       (rc_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .dq_in      (dq_in),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .ry_by      (ry_by),
        .status_in  (status_in),
        .mem_rd_req (mem_rd_req),
        .mem_wr_req (mem_wr_req),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [7:0] arr_byte(input logic [17:0] a);
        return a[7:0] ^ {1'b0, a[17:11]} ^ {a[10:8], 5'b0} ^ 8'h5A;
    endfunction

    // Memory model and request monitor
    always @(posedge clk) begin
        if (mem_rd_req) begin
            mem_rdata    <= arr_byte(mem_addr);
            rd_cnt       <= rd_cnt + 1;
            rd_addr_seen <= mem_addr;
        end
        if (mem_wr_req) begin
            wr_cnt       <= wr_cnt + 1;
            wr_addr_seen <= mem_addr;
            wr_data_seen <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_addr(input logic [17:0] a);
        @(negedge clk);
        addr_in = a[10:0];
        rc_n    = 1'b0;
        wait_n(5);
        addr_in = {4'b0, a[17:11]};
        rc_n    = 1'b1;
        wait_n(5);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        dq_in = d;
        we_n  = 1'b0;
        wait_n(4);
        we_n = 1'b1;
        wait_n(6);
    endtask

    // Returns the byte seen on the bus and whether it was driven
    task automatic host_read(output logic [7:0] d, output logic oe_seen, output logic oe_after);
        @(negedge clk);
        oe_n = 1'b0;
        wait_n(8);
        d       = dq_out;
        oe_seen = dq_oe;
        oe_n    = 1'b1;
        #1;
        oe_after = dq_oe;
        wait_n(4);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic        oe_seen;
        logic        oe_after;
        logic [17:0] a;
        int          w0;
        int          r0;

        wait_n(3);
        // R9: reset state
        chk(mem_wr_req == 0, "R9 wr_req", mem_wr_req, 0);
        chk(mem_rd_req == 0, "R9 rd_req", mem_rd_req, 0);
        chk(dq_oe == 0, "R9 dq_oe", dq_oe, 0);
        chk(mem_addr == 0, "R9 mem_addr", mem_addr, 0);
        rst_n = 1'b1;
        wait_n(3);

        // R8: every status byte
        for (int s = 0; s < 256; s++) begin
            status_in = s[7:0];
            #1;
            chk(ry_by == s[7], "R8 ry_by", ry_by, s[7]);
        end
        status_in = 8'h80;

        // R1 R2 R3 R5 R7: walking ones, walking zeros and mixed patterns
        for (int k = 0; k < 40; k++) begin
            if (k < 18)       a = 18'(1) << k;
            else if (k < 36)  a = ~(18'(1) << (k - 18));
            else              a = 18'(32'h9E37_79B9 * (k + 1));
            w0 = wr_cnt;
            load_addr(a);
            host_write(a[7:0] ^ 8'hC3);
            chk(wr_cnt == w0 + 1, "R3 one write pulse", wr_cnt, w0 + 1);
            chk(wr_addr_seen[10:0] == a[10:0], "R1 row bits", wr_addr_seen[10:0], a[10:0]);
            chk(wr_addr_seen[17:11] == a[17:11], "R2 column bits", wr_addr_seen[17:11], a[17:11]);
            chk(wr_data_seen == (a[7:0] ^ 8'hC3), "R3 write data", wr_data_seen, a[7:0] ^ 8'hC3);
            r0 = rd_cnt;
            host_read(d, oe_seen, oe_after);
            chk(rd_cnt == r0 + 1, "R5 one read pulse", rd_cnt, r0 + 1);
            chk(rd_addr_seen == a, "R5 read address", rd_addr_seen, a);
            chk(d == arr_byte(a), "R5 read data", d, arr_byte(a));
            chk(oe_seen == 1, "R5 bus driven", oe_seen, 1);
            chk(oe_after == 0, "R7 release on oe_n rise", oe_after, 0);
            chk(dq_oe == 0, "R7 idle bus", dq_oe, 0);
        end

        // R4 R6: busy for a range of status bytes
        a = 18'h2B5C6;
        load_addr(a);
        for (int s = 0; s < 128; s += 9) begin
            status_in = s[7:0];
            w0 = wr_cnt;
            r0 = rd_cnt;
            host_write(8'hEE);
            chk(wr_cnt == w0, "R4 write ignored when busy", wr_cnt, w0);
            host_read(d, oe_seen, oe_after);
            chk(rd_cnt == r0, "R6 no read request when busy", rd_cnt, r0);
            chk(d == s[7:0], "R6 status byte returned", d, s);
            chk(oe_seen == 1, "R6 bus driven", oe_seen, 1);
            chk(oe_after == 0, "R7 release when busy", oe_after, 0);
        end

        // Ready again: a write goes through and the old address is reused
        status_in = 8'h80;
        w0 = wr_cnt;
        host_write(8'h3C);
        chk(wr_cnt == w0 + 1, "R3 write after busy", wr_cnt, w0 + 1);
        chk(wr_addr_seen == a, "R2 address kept", wr_addr_seen, a);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule